// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

This block buffers up to 64 words of 36 bits between two unrelated clock domains. Port A writes on `clk_a` and port B reads on `clk_b`. Each side keeps its own binary pointer and a Gray-coded copy of it. The Gray copy crosses to the other domain through a two-flop synchroniser. The write domain therefore computes the full and almost-full flags, and the read domain computes the empty and almost-empty flags. Because of the synchroniser, a flag can lag the far side by a few cycles, but it is always conservative.

A single active-low reset, `rst_n`, may change at any time relative to either clock. It must stay low for at least four rising edges of each clock. On its rising edge it latches a two-bit `flag_sel` into an offset register, which sets the almost-full and almost-empty threshold.

The write side runs a three-state sequencer:
- `W_HOLD` is entered asynchronously while reset is low.
- `W_HOLD -> W_ARM` happens on the first `clk_a` edge after reset is released.
- `W_ARM -> W_RUN` happens on the second edge.
- `W_RUN` holds until the next reset.

The read side runs a two-state sequencer, `R_HOLD -> R_RUN`, which takes one `clk_b` edge. Flags are forced to their reset values in every state other than the running state. Port B has a registered data output and a separate output-enable signal in place of a pad driver.

Top module: `dual_clk_fifo`

## Requirements
- R1: While `rst_n` is low, `full_n`, `empty_n` and `aempty_n` are low, `afull_n` is high, and both pointers are cleared, so the FIFO reads as empty after reset.
- R2: After `rst_n` rises, `full_n` is still low after the first rising `clk_a` edge and is high after the second.
- R3: The rising edge of `rst_n` loads the threshold X from `flag_sel`: 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 12, 2'b11 gives 16.
- R4: A word is stored on a rising `clk_a` edge only when `a_cs_n`=0, `a_wr`=1, `a_en`=1, `a_mb`=0 and `full_n`=1. Any other combination stores nothing.
- R5: A read happens on a rising `clk_b` edge when `b_cs_n`=0, `b_wr`=0, `b_en`=1, `b_mb`=0 and `empty_n`=1. The word is on `b_data` after that same edge, and words leave in the order they were written.
- R6: `empty_n` is low exactly when the read side sees zero stored words.
- R7: `aempty_n` is low when the stored word count is X or less.
- R8: `afull_n` is low when the free space is X words or less.
- R9: `full_n` is low when 64 words are stored.
- R10: A write attempted while `full_n` is low is dropped and does not move the write pointer.
- R11: A read attempted while `empty_n` is low does not move the read pointer, and `b_data` keeps its value.
- R12: `b_oe` is high only when `b_cs_n` and `b_wr` are both low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Write-side clock |
| clk_b | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset; its rising edge latches `flag_sel` |
| flag_sel | input | 2 | Threshold select, sampled when reset is released |
| a_cs_n | input | 1 | Port A chip select, active low |
| a_wr | input | 1 | Port A direction, 1 = write |
| a_en | input | 1 | Port A enable |
| a_mb | input | 1 | Port A mailbox select; 1 blocks FIFO writes |
| a_data | input | 36 | Write data |
| full_n | output | 1 | Low when full or during reset |
| afull_n | output | 1 | Low when free space is at or below the threshold |
| b_cs_n | input | 1 | Port B chip select, active low |
| b_wr | input | 1 | Port B direction, 0 = read |
| b_en | input | 1 | Port B enable |
| b_mb | input | 1 | Port B mailbox select; 1 blocks FIFO reads |
| b_data | output | 36 | Registered read data |
| b_oe | output | 1 | Output enable for the port B data |
| empty_n | output | 1 | Low when empty or during reset |
| aempty_n | output | 1 | Low when the stored count is at or below the threshold |

## Verification
The hardest conditions to reach from the ports are the edges of the almost-full window and the full state itself. Reaching them needs about 50 to 64 accepted writes, with exactly the right threshold latched beforehand. The flags also settle only after the pointer has crossed the synchroniser into the other domain.

The bench uses a table of entries, each holding a select code, a fill count and the four expected flags. For each entry it resets with that select, writes exactly that many words, and waits for both domains to settle before sampling. Directed tests then cover the two-edge release of full, blocked writes at full followed by a complete drain, reads on an empty FIFO, and each write qualifier held in its blocking state.

// File: rtl/dcf_pkg.sv
`timescale 1ns/1ps
package dcf_pkg;

    typedef enum logic [1:0] {
        W_HOLD = 2'd0,
        W_ARM  = 2'd1,
        W_RUN  = 2'd2
    } wr_phase_e;

    typedef enum logic {
        R_HOLD = 1'b0,
        R_RUN  = 1'b1
    } rd_phase_e;

    // Threshold grows in steps of four with the select code.
    function automatic int unsigned flag_offset(input logic [1:0] sel);
        return (int'(sel) + 1) * 4;
    endfunction

endpackage

// File: rtl/dcf_gray_sync.sv
`timescale 1ns/1ps
module dcf_gray_sync #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcf_wr_side.sv
`timescale 1ns/1ps
module dcf_wr_side
    import dcf_pkg::*;
#(
    parameter int AW = 6,
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] offset,
    input  logic          wr_req,
    input  logic [PW-1:0] rgray_s,
    output logic [PW-1:0] wbin,
    output logic [PW-1:0] wgray,
    output logic          wen,
    output logic          full_n,
    output logic          afull_n
);
    localparam int DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

    wr_phase_e     phase, phase_nx;
    logic [PW-1:0] wbin_nx, rbin_s, used, free;
    logic          full;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            rbin_s[i] = ^(rgray_s >> i);
        end
    end

    assign used    = wbin - rbin_s;
    assign free    = DEPTH_V - used;
    assign full    = (used == DEPTH_V);
    assign wen     = wr_req && full_n;
    assign wbin_nx = wbin + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= W_HOLD;
        else        phase <= phase_nx;
    end

    always_comb begin
        unique case (phase)
            W_HOLD:  phase_nx = W_ARM;
            W_ARM:   phase_nx = W_RUN;
            W_RUN:   phase_nx = W_RUN;
            default: phase_nx = W_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        full_n  = 1'b0;
        afull_n = 1'b1;
        unique case (phase)
            W_RUN: begin
                full_n  = !full;
                afull_n = (free > offset);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (wen) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end
endmodule

// File: rtl/dcf_rd_side.sv
`timescale 1ns/1ps
module dcf_rd_side
    import dcf_pkg::*;
#(
    parameter int AW = 6,
    localparam int PW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [PW-1:0] offset,
    input  logic          rd_req,
    input  logic [PW-1:0] wgray_s,
    output logic [PW-1:0] rbin,
    output logic [PW-1:0] rgray,
    output logic          ren,
    output logic          empty_n,
    output logic          aempty_n
);
    rd_phase_e     phase, phase_nx;
    logic [PW-1:0] rbin_nx, wbin_s, used;

    always_comb begin
        for (int i = 0; i < PW; i++) begin
            wbin_s[i] = ^(wgray_s >> i);
        end
    end

    assign used    = wbin_s - rbin;
    assign ren     = rd_req && empty_n;
    assign rbin_nx = rbin + 1'b1;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase <= R_HOLD;
        else        phase <= phase_nx;
    end

    always_comb begin
        unique case (phase)
            R_HOLD:  phase_nx = R_RUN;
            R_RUN:   phase_nx = R_RUN;
            default: phase_nx = R_HOLD;
        endcase
    end

    // outputs
    always_comb begin
        empty_n  = 1'b0;
        aempty_n = 1'b0;
        unique case (phase)
            R_RUN: begin
                empty_n  = (rgray != wgray_s);
                aempty_n = (used > offset);
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
        end else if (ren) begin
            rbin  <= rbin_nx;
            rgray <= rbin_nx ^ (rbin_nx >> 1);
        end
    end
endmodule

// File: rtl/dual_clk_fifo.sv
`timescale 1ns/1ps
module dual_clk_fifo #(
    parameter int AW = 6,
    parameter int DW = 36
) (
    input  logic          clk_a,
    input  logic          clk_b,
    input  logic          rst_n,
    input  logic [1:0]    flag_sel,
    input  logic          a_cs_n,
    input  logic          a_wr,
    input  logic          a_en,
    input  logic          a_mb,
    input  logic [DW-1:0] a_data,
    output logic          full_n,
    output logic          afull_n,
    input  logic          b_cs_n,
    input  logic          b_wr,
    input  logic          b_en,
    input  logic          b_mb,
    output logic [DW-1:0] b_data,
    output logic          b_oe,
    output logic          empty_n,
    output logic          aempty_n
);
    localparam int DEPTH = 1 << AW;
    localparam int PW    = AW + 1;

    logic [PW-1:0] offset;
    logic [PW-1:0] w_bin, w_gray, w_gray_s;
    logic [PW-1:0] r_bin, r_gray, r_gray_s;
    logic          wen, ren;
    logic [DW-1:0] mem [DEPTH];

    // Threshold captured when reset is released.
    always_ff @(posedge rst_n) begin
        offset <= PW'(dcf_pkg::flag_offset(flag_sel));
    end

    dcf_wr_side #(.AW(AW)) u_wr (
        .clk     (clk_a),
        .rst_n   (rst_n),
        .offset  (offset),
        .wr_req  (!a_cs_n && a_wr && a_en && !a_mb),
        .rgray_s (r_gray_s),
        .wbin    (w_bin),
        .wgray   (w_gray),
        .wen     (wen),
        .full_n  (full_n),
        .afull_n (afull_n)
    );

    dcf_rd_side #(.AW(AW)) u_rd (
        .clk      (clk_b),
        .rst_n    (rst_n),
        .offset   (offset),
        .rd_req   (!b_cs_n && !b_wr && b_en && !b_mb),
        .wgray_s  (w_gray_s),
        .rbin     (r_bin),
        .rgray    (r_gray),
        .ren      (ren),
        .empty_n  (empty_n),
        .aempty_n (aempty_n)
    );

    dcf_gray_sync #(.W(PW)) u_w2r (
        .clk (clk_b), .rst_n (rst_n), .d (w_gray), .q (w_gray_s)
    );

    dcf_gray_sync #(.W(PW)) u_r2w (
        .clk (clk_a), .rst_n (rst_n), .d (r_gray), .q (r_gray_s)
    );

    always_ff @(posedge clk_a) begin
        if (wen) mem[w_bin[AW-1:0]] <= a_data;
    end

    always_ff @(posedge clk_b or negedge rst_n) begin
        if (!rst_n)   b_data <= '0;
        else if (ren) b_data <= mem[r_bin[AW-1:0]];
    end

    assign b_oe = !b_cs_n && !b_wr;
endmodule

// File: rtl/dcf_chk.sv
`timescale 1ns/1ps
module dcf_chk #(
    parameter int PW = 7
) (
    input logic          clk_a,
    input logic          clk_b,
    input logic          rst_n,
    input logic          full_n,
    input logic          afull_n,
    input logic          empty_n,
    input logic          aempty_n,
    input logic          b_wr,
    input logic          b_oe,
    input logic [PW-1:0] w_bin,
    input logic [PW-1:0] r_bin
);
    always @(posedge clk_a) begin
        if (!rst_n) begin
            // R1
            reset_wflags_chk: assert (!full_n && afull_n);
        end
    end

    always @(posedge clk_b) begin
        if (!rst_n) begin
            // R1
            reset_rflags_chk: assert (!empty_n && !aempty_n);
        end
    end

    // R10
    wr_hold_full_chk: assert property (@(posedge clk_a) disable iff (!rst_n)
        !full_n |=> $stable(w_bin));

    // R11
    rd_hold_empty_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !empty_n |=> $stable(r_bin));

    // R7
    empty_is_low_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        !empty_n |-> !aempty_n);

    // R12
    oe_off_write_chk: assert property (@(posedge clk_b) disable iff (!rst_n)
        b_wr |-> !b_oe);
endmodule

bind dual_clk_fifo dcf_chk #(.PW(AW + 1)) u_chk (
    .clk_a    (clk_a),
    .clk_b    (clk_b),
    .rst_n    (rst_n),
    .full_n   (full_n),
    .afull_n  (afull_n),
    .empty_n  (empty_n),
    .aempty_n (aempty_n),
    .b_wr     (b_wr),
    .b_oe     (b_oe),
    .w_bin    (w_bin),
    .r_bin    (r_bin)
);

// File: tb/dual_clk_fifo_bench.sv
`timescale 1ns/1ps
module dual_clk_fifo_bench;

    logic        clk_a = 0, clk_b = 0, rst_n = 0;
    logic [1:0]  flag_sel = 2'b00;
    logic        a_cs_n = 1, a_wr = 0, a_en = 0, a_mb = 0;
    logic [35:0] a_data = '0;
    logic        b_cs_n = 1, b_wr = 1, b_en = 0, b_mb = 0;
    logic        full_n, afull_n, empty_n, aempty_n, b_oe;
    logic [35:0] b_data;

    int ncheck = 0, nfail = 0;
    bit done = 0;

    always #2.5 clk_a = ~clk_a;
    always #3.5 clk_b = ~clk_b;

    dual_clk_fifo u_dual_clk_fifo (
        .clk_a(clk_a), .clk_b(clk_b), .rst_n(rst_n), .flag_sel(flag_sel),
        .a_cs_n(a_cs_n), .a_wr(a_wr), .a_en(a_en), .a_mb(a_mb), .a_data(a_data),
        .full_n(full_n), .afull_n(afull_n),
        .b_cs_n(b_cs_n), .b_wr(b_wr), .b_en(b_en), .b_mb(b_mb),
        .b_data(b_data), .b_oe(b_oe), .empty_n(empty_n), .aempty_n(aempty_n)
    );

    typedef struct packed {
        logic [1:0] fs;
        logic [6:0] n;
        logic       x_full_n;
        logic       x_afull_n;
        logic       x_empty_n;
        logic       x_aempty_n;
    } vec_t;

    // fill count vs flags; threshold X = 4,8,12,16 for fs 0..3
    localparam vec_t VECS [10] = '{
        '{2'd0, 7'd0,  1'b1, 1'b1, 1'b0, 1'b0},
        '{2'd0, 7'd4,  1'b1, 1'b1, 1'b1, 1'b0},
        '{2'd0, 7'd5,  1'b1, 1'b1, 1'b1, 1'b1},
        '{2'd1, 7'd8,  1'b1, 1'b1, 1'b1, 1'b0},
        '{2'd1, 7'd9,  1'b1, 1'b1, 1'b1, 1'b1},
        '{2'd2, 7'd52, 1'b1, 1'b0, 1'b1, 1'b1},
        '{2'd2, 7'd51, 1'b1, 1'b1, 1'b1, 1'b1},
        '{2'd3, 7'd48, 1'b1, 1'b0, 1'b1, 1'b1},
        '{2'd3, 7'd47, 1'b1, 1'b1, 1'b1, 1'b1},
        '{2'd3, 7'd64, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        ncheck++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", ncheck - nfail, ncheck);
            $finish;
        end
    endtask

    task automatic settle();
        repeat (4) @(posedge clk_a);
        repeat (4) @(posedge clk_b);
        #1;
    endtask

    task automatic hold_reset(input logic [1:0] fs);
        @(negedge clk_a);
        rst_n = 0;
        flag_sel = fs;
        repeat (5) @(posedge clk_a);
        repeat (5) @(posedge clk_b);
        @(negedge clk_a);
        rst_n = 1;
    endtask

    task automatic wr(input logic [35:0] d);
        @(negedge clk_a);
        a_cs_n = 0; a_wr = 1; a_en = 1; a_mb = 0; a_data = d;
        @(negedge clk_a);
        a_en = 0;
    endtask

    task automatic rd(output logic [35:0] v);
        @(negedge clk_b);
        b_cs_n = 0; b_wr = 0; b_en = 1; b_mb = 0;
        @(posedge clk_b);
        #1 v = b_data;
        @(negedge clk_b);
        b_en = 0;
    endtask

    initial begin
        #600000;
        ncheck++;
        nfail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        finish_run();
    end

    initial begin
        logic [35:0] v;

        // R3 R6 R7 R8 R9: table of fill levels per threshold
        for (int k = 0; k < 10; k++) begin
            hold_reset(VECS[k].fs);
            settle();
            for (int i = 0; i < int'(VECS[k].n); i++) wr(36'h100 + 36'(i));
            settle();
            chk("R9 full_n",   64'(full_n),   64'(VECS[k].x_full_n));
            chk("R8/R3 afull_n", 64'(afull_n), 64'(VECS[k].x_afull_n));
            chk("R6 empty_n",  64'(empty_n),  64'(VECS[k].x_empty_n));
            chk("R7/R3 aempty_n", 64'(aempty_n), 64'(VECS[k].x_aempty_n));
        end

        // R1: reset with a full FIFO
        @(negedge clk_a);
        rst_n = 0;
        flag_sel = 2'b00;
        repeat (5) @(posedge clk_a);
        repeat (5) @(posedge clk_b);
        #1;
        chk("R1 full_n",   64'(full_n),   64'd0);
        chk("R1 afull_n",  64'(afull_n),  64'd1);
        chk("R1 empty_n",  64'(empty_n),  64'd0);
        chk("R1 aempty_n", 64'(aempty_n), 64'd0);
        // R2: full_n released on the second write-clock edge
        @(negedge clk_a);
        rst_n = 1;
        @(posedge clk_a); #1;
        chk("R2 full_n edge1", 64'(full_n), 64'd0);
        @(posedge clk_a); #1;
        chk("R2 full_n edge2", 64'(full_n), 64'd1);
        settle();
        chk("R1 cleared empty_n", 64'(empty_n), 64'd0);

        // R4: each blocking qualifier stores nothing
        @(negedge clk_a);
        a_cs_n = 0; a_wr = 1; a_en = 1; a_mb = 1; a_data = 36'hBAD;
        @(negedge clk_a);
        a_mb = 0; a_cs_n = 1;
        @(negedge clk_a);
        a_cs_n = 0; a_wr = 0;
        @(negedge clk_a);
        a_wr = 1; a_en = 0;
        @(negedge clk_a);
        settle();
        chk("R4 blocked writes empty_n", 64'(empty_n), 64'd0);

        // R5 R12: order and output enable
        for (int i = 0; i < 5; i++) wr(36'hA_5000_0000 + 36'(i * 3));
        settle();
        for (int i = 0; i < 5; i++) begin
            rd(v);
            chk("R5 data", 64'(v), 64'(36'hA_5000_0000 + 36'(i * 3)));
        end
        @(negedge clk_b);
        b_cs_n = 0; b_wr = 0; #1;
        chk("R12 oe on", 64'(b_oe), 64'd1);
        b_wr = 1; #1;
        chk("R12 oe wr", 64'(b_oe), 64'd0);
        b_wr = 0; b_cs_n = 1; #1;
        chk("R12 oe cs", 64'(b_oe), 64'd0);
        settle();

        // R11: read while empty leaves data and pointer
        rd(v);
        chk("R11 data held", 64'(v), 64'(36'hA_5000_000C));
        wr(36'h7_7777_7777);
        settle();
        rd(v);
        chk("R11 next word", 64'(v), 64'(36'h7_7777_7777));

        // R10: writes at full are dropped
        hold_reset(2'b11);
        settle();
        for (int i = 0; i < 64; i++) wr(36'h3_0000_0000 + 36'(i));
        wr(36'hF_FFFF_FFFF);
        wr(36'hF_FFFF_FFFE);
        settle();
        chk("R10 full_n", 64'(full_n), 64'd0);
        for (int i = 0; i < 64; i++) begin
            rd(v);
            chk("R10 drain", 64'(v), 64'(36'h3_0000_0000 + 36'(i)));
        end
        settle();
        chk("R10 empty after drain", 64'(empty_n), 64'd0);

        finish_run();
    end
endmodule